// File: doc/BRIEF.md
# Condition-Flag ALU

This block pairs a 64-bit integer arithmetic unit with a four-bit condition flag register. Each cycle it takes two operands, an operation select (add, subtract, bitwise AND) and a flag-mode code. The mode decides what happens to the flags. They can be left untouched, written from the operation, used as a carry input, or both used and written. The mode can also copy the flags to or from a status word. A processor that executes code written for a flag-based machine can then carry the flags in hardware, with no extra instructions spent rebuilding them.

The result is combinational from the operands and the stored flags. The flag register updates on the rising clock edge, so the operation in the next cycle already sees the new flags. A conditional-compare option lets a flag-writing operation test a four-bit condition code against the current flags. When the condition fails, a four-bit immediate is loaded into the flags instead of the computed ones.

Top module: `cond_flag_alu`

## Requirements
- R1: A synchronous active-high reset clears all four flags. `flags_o` packs them as bit 3 negative (N), bit 2 zero (Z), bit 1 carry (C) and bit 0 overflow (V).
- R2: In write mode (`flag_mode`=1), add (`alu_op`=0) and subtract (`alu_op`=1) compute a+b and a−b. The flags are then set as follows: N is the top bit of the result and Z is 1 when the result is all zeros. C is the unsigned carry-out for add, and for subtract C is 0 on a borrow and 1 otherwise. V is signed two's-complement overflow.
- R3: A flag-writing AND (`alu_op`=2) sets N and Z from the result and clears C and V.
- R4: In hold mode (`flag_mode`=0, and the unused codes 6 and 7), `result` is still produced and the flags keep their value.
- R5: In carry-use mode (`flag_mode`=2), add gives a+b+C and subtract gives a+~b+C, and the flags keep their value. In every mode that does not use the carry, subtract gives a−b.
- R6: In use-and-write mode (`flag_mode`=3), the carry-consuming operation runs and all four flags are then written from its own result, as in R2/R3.
- R7: Status write (`flag_mode`=4) loads N,Z,C,V from `op_a` bits 31,30,29,28. `result` is 0 in this mode.
- R8: Status read (`flag_mode`=5) returns N,Z,C,V in `result` bits 31..28, with every other bit zero, and the flags do not change.
- R9: With `ccmp_en`=1 in modes 1 or 3, a true condition writes the flags as usual. A false condition loads the flags from `ccmp_nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). In every other mode `ccmp_en` has no effect.
- R10: `cond_sel` codes: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). Codes 14 and 15 are always true.
- R11: A flag update is seen by the operation in the very next cycle, with no idle cycle in between.
- R12: `alu_op`=3 behaves exactly as AND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand; bits 31:28 are the status-write source |
| op_b | input | 64 | Second operand |
| alu_op | input | 2 | 0 add, 1 subtract, 2/3 AND |
| flag_mode | input | 3 | 0 hold, 1 write, 2 use carry, 3 use and write, 4 status write, 5 status read |
| ccmp_en | input | 1 | Enables the conditional-compare override |
| cond_sel | input | 4 | Condition code tested against the current flags |
| ccmp_nzcv | input | 4 | Flags loaded when the tested condition is false |
| result | output | 64 | Operation result, or the status word |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
A corrupted flag register is visible on `flags_o` one edge after the update that went wrong. Within the same cycle it also changes `result` for any carry-use operation or status read that follows. A wrong carry-in or overflow term shows up in the combinational `result` or in the flags one edge later. Comparing both outputs on every cycle against a behavioural model therefore catches a fault at most one cycle after it happens. Condition-code faults only appear when the code is false on the current flags, so every code is tested against flag states that make it both true and false.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_AND2 = 2'd3
    } alu_op_e;

    typedef enum logic [2:0] {
        FM_NONE = 3'd0,
        FM_SET  = 3'd1,
        FM_USE  = 3'd2,
        FM_BOTH = 3'd3,
        FM_WR   = 3'd4,
        FM_RD   = 3'd5,
        FM_RS6  = 3'd6,
        FM_RS7  = 3'd7
    } flag_mode_e;

    // R10: condition code evaluation against the stored flags
    function automatic logic cond_holds(input logic [3:0] code, input nzcv_t f);
        logic base;
        case (code[3:1])
            3'd0:    base = f.z;
            3'd1:    base = f.c;
            3'd2:    base = f.n;
            3'd3:    base = f.v;
            3'd4:    base = f.c & ~f.z;
            3'd5:    base = (f.n == f.v);
            3'd6:    base = ~f.z & (f.n == f.v);
            default: base = 1'b1;
        endcase
        if (code[3:1] == 3'd7) return 1'b1;
        return code[0] ? ~base : base;
    endfunction

endpackage

// File: rtl/cfa_alu.sv
module cfa_alu
    import cfa_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         carry_use,
    input  logic         carry_in,
    output logic [W-1:0] res,
    output nzcv_t        fl
);
    logic         is_sub;
    logic         arith;
    logic         cin;
    logic [W-1:0] bx;
    logic [W:0]   sum;

    always_comb begin
        is_sub = (op == ALU_SUB);
        arith  = (op == ALU_ADD) || is_sub;
        bx     = is_sub ? ~b : b;
        cin    = carry_use ? carry_in : is_sub;
        sum    = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
        res    = arith ? sum[W-1:0] : (a & b);
        fl.n   = res[W-1];
        fl.z   = (res == '0);
        fl.c   = arith & sum[W];
        fl.v   = arith & (a[W-1] == bx[W-1]) & (res[W-1] != a[W-1]);
    end

endmodule

// File: rtl/cfa_cond.sv
module cfa_cond
    import cfa_pkg::*;
(
    input  logic [3:0] code,
    input  nzcv_t      flags,
    output logic       holds
);
    assign holds = cond_holds(code, flags);
endmodule

// File: rtl/cfa_flagreg.sv
module cfa_flagreg
    import cfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flag_mode_e mode,
    input  logic       ccmp_en,
    input  logic       cond_ok,
    input  nzcv_t      alu_fl,
    input  nzcv_t      wr_fl,
    input  nzcv_t      imm_fl,
    output nzcv_t      flags_q
);
    nzcv_t flags_d;
    logic  writes;

    always_comb begin
        writes  = (mode == FM_SET) || (mode == FM_BOTH);
        flags_d = flags_q;
        if (writes)
            flags_d = (ccmp_en && !cond_ok) ? imm_fl : alu_fl;
        else if (mode == FM_WR)
            flags_d = wr_fl;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (flags_q == '0));

    a_r4_hold_mode: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_NONE || mode == FM_USE || mode == FM_RD) |=> (flags_q == $past(flags_q)));

    a_r7_status_write: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_WR) |=> (flags_q == $past(wr_fl)));

    a_r9_ccmp_false: assert property (@(posedge clk) disable iff (rst)
        (writes && ccmp_en && !cond_ok) |=> (flags_q == $past(imm_fl)));

endmodule

// File: rtl/cond_flag_alu.sv
module cond_flag_alu
    import cfa_pkg::*;
#(
    parameter int W        = 64,
    parameter int FLAG_LSB = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   alu_op,
    input  logic [2:0]   flag_mode,
    input  logic         ccmp_en,
    input  logic [3:0]   cond_sel,
    input  logic [3:0]   ccmp_nzcv,
    output logic [W-1:0] result,
    output logic [3:0]   flags_o
);
    localparam int FLAG_MSB = FLAG_LSB + 3;

    flag_mode_e   mode;
    alu_op_e      op;
    nzcv_t        flags_q;
    nzcv_t        alu_fl;
    logic [W-1:0] alu_res;
    logic [W-1:0] rd_word;
    logic         carry_use;
    logic         cond_ok;

    assign mode      = flag_mode_e'(flag_mode);
    assign op        = alu_op_e'(alu_op);
    assign carry_use = (mode == FM_USE) || (mode == FM_BOTH);

    cfa_alu #(.W(W)) u_alu (
        .a         (op_a),
        .b         (op_b),
        .op        (op),
        .carry_use (carry_use),
        .carry_in  (flags_q.c),
        .res       (alu_res),
        .fl        (alu_fl)
    );

    cfa_cond u_cond (
        .code  (cond_sel),
        .flags (flags_q),
        .holds (cond_ok)
    );

    cfa_flagreg u_flags (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .ccmp_en (ccmp_en),
        .cond_ok (cond_ok),
        .alu_fl  (alu_fl),
        .wr_fl   (nzcv_t'(op_a[FLAG_MSB:FLAG_LSB])),
        .imm_fl  (nzcv_t'(ccmp_nzcv)),
        .flags_q (flags_q)
    );

    always_comb begin
        rd_word                    = '0;
        rd_word[FLAG_MSB:FLAG_LSB] = flags_q;
        case (mode)
            FM_RD:   result = rd_word;
            FM_WR:   result = '0;
            default: result = alu_res;
        endcase
    end

    assign flags_o = flags_q;

    a_r5_carry_add: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_USE && op == ALU_ADD) |-> (result == op_a + op_b + W'(flags_o[1])));

    a_r8_status_read: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_RD) |-> ((result >> FLAG_LSB) == W'(flags_o)));

    a_r3_logic_clears: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_SET && alu_op[1] && !ccmp_en) |=> (flags_o[1:0] == 2'b00));

endmodule

// File: tb/cond_flag_alu_tb.sv
module cond_flag_alu_tb;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] op_a, op_b;
    logic [1:0]   alu_op;
    logic [2:0]   flag_mode;
    logic         ccmp_en;
    logic [3:0]   cond_sel, ccmp_nzcv;
    logic [W-1:0] result;
    logic [3:0]   flags_o;

    int total = 0;
    int bad   = 0;
    logic [3:0] mf;

    always #10 clk = ~clk;

    cond_flag_alu u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .alu_op(alu_op),
        .flag_mode(flag_mode), .ccmp_en(ccmp_en), .cond_sel(cond_sel),
        .ccmp_nzcv(ccmp_nzcv), .result(result), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic cond_ref(input logic [3:0] code, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (code)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] op, input logic [2:0] mode,
                         input logic cen, input logic [3:0] cs, input logic [3:0] imm);
        logic            use_c, cin, wr;
        logic [W:0]      u;
        logic signed [W+1:0] s;
        logic [W-1:0]    r, er;
        logic [3:0]      af, nf;
        use_c = (mode == 3'd2) || (mode == 3'd3);
        if (op == 2'd0) begin
            cin = use_c ? mf[1] : 1'b0;
            u = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
            s = {{2{a[W-1]}}, a} + {{2{b[W-1]}}, b} + (W+2)'(cin);
            r = u[W-1:0];
            af = {r[W-1], r == '0, u[W], s[W] != s[W-1]};
        end else if (op == 2'd1) begin
            cin = use_c ? mf[1] : 1'b1;
            u = {1'b0, a} - {1'b0, b} - (W+1)'(!cin);
            s = {{2{a[W-1]}}, a} - {{2{b[W-1]}}, b} - (W+2)'(!cin);
            r = u[W-1:0];
            af = {r[W-1], r == '0, !u[W], s[W] != s[W-1]};
        end else begin
            r = a & b;
            af = {r[W-1], r == '0, 2'b00};
        end
        wr = (mode == 3'd1) || (mode == 3'd3);
        nf = mf;
        if (wr) nf = (cen && !cond_ref(cs, mf)) ? imm : af;
        else if (mode == 3'd4) nf = a[31:28];
        er = r;
        if (mode == 3'd4) er = '0;
        if (mode == 3'd5) er = {32'd0, mf, 28'd0};

        @(negedge clk);
        op_a = a; op_b = b; alu_op = op; flag_mode = mode;
        ccmp_en = cen; cond_sel = cs; ccmp_nzcv = imm;
        #2 chk({tag, " result"}, result, er);
        @(posedge clk);
        #1 chk({tag, " flags"}, W'(flags_o), W'(nf));
        mf = nf;
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom % 6)
            0: return '0;
            1: return '1;
            2: return {1'b1, {(W-1){1'b0}}};
            3: return {1'b0, {(W-1){1'b1}}};
            4: return W'($urandom % 8);
            default: return {$urandom, $urandom};
        endcase
    endfunction

    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] MINS = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXS = {1'b0, {(W-1){1'b1}}};

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; op_a = '0; op_b = '0; alu_op = '0; flag_mode = '0;
        ccmp_en = 1'b0; cond_sel = '0; ccmp_nzcv = '0;
        mf = 4'h0;
        repeat (3) @(posedge clk);
        #1 chk("R1 reset", W'(flags_o), '0);
        @(negedge clk); rst = 1'b0;

        // R2: add and subtract flag generation
        apply("R2 add wrap", ONES, 1, 0, 1, 0, 0, 0);
        apply("R2 add ovf", MAXS, 1, 0, 1, 0, 0, 0);
        apply("R2 sub equal", 5, 5, 1, 1, 0, 0, 0);
        apply("R2 sub borrow", 3, 5, 1, 1, 0, 0, 0);
        apply("R2 sub ovf", MINS, 1, 1, 1, 0, 0, 0);
        // R3: logic op clears C and V
        apply("R2 carry set", ONES, 2, 0, 1, 0, 0, 0);
        apply("R3 and neg", MINS, ONES, 2, 1, 0, 0, 0);
        apply("R3 and zero", 64'hF0, 64'h0F, 2, 1, 0, 0, 0);
        // R12: op code 3 acts as AND
        apply("R2 ovf again", MAXS, 1, 0, 1, 0, 0, 0);
        apply("R12 op3", MINS, MINS, 3, 1, 0, 0, 0);
        // R4: hold modes
        apply("R2 set C", ONES, 1, 0, 1, 0, 0, 0);
        apply("R4 none", MAXS, 1, 0, 0, 0, 0, 0);
        apply("R4 code6", 7, 9, 1, 6, 0, 0, 0);
        apply("R4 code7", 0, 0, 2, 7, 1, 1, 4'hF);
        // R5: carry use, flags kept
        apply("R5 adc C1", 10, 20, 0, 2, 0, 0, 0);
        apply("R5 sbc C1", 10, 3, 1, 2, 0, 0, 0);
        apply("R2 clear C", 0, 0, 0, 1, 0, 0, 0);
        apply("R5 adc C0", 10, 20, 0, 2, 0, 0, 0);
        apply("R5 sbc C0", 10, 3, 1, 2, 0, 0, 0);
        // R6 and R11: use-and-write, back to back
        apply("R6 adcs wrap", ONES, 1, 0, 3, 0, 0, 0);
        apply("R11 next sees C", 1, 1, 0, 3, 0, 0, 0);
        apply("R6 sbcs", 0, 0, 1, 3, 0, 0, 0);
        apply("R11 sbc borrow", 0, 0, 1, 3, 0, 0, 0);
        // R7 and R8: status word
        apply("R7 write", 64'hFFFF_FFFF_A000_0000, 0, 0, 4, 0, 0, 0);
        apply("R8 read", ONES, ONES, 1, 5, 0, 0, 0);
        apply("R7 write2", 64'h5000_0000, 0, 0, 4, 0, 0, 0);
        apply("R8 read2", 0, 0, 0, 5, 1, 0, 4'hF);
        // R9: conditional compare
        apply("R9 ccmp true", 5, 5, 1, 1, 1, 4'd14, 4'h3);
        apply("R9 ccmp false", 5, 5, 1, 1, 1, 4'd1, 4'h3);
        apply("R9 ccmp both mode", 1, 2, 0, 3, 1, 4'd0, 4'hC);
        apply("R9 ignored none", 1, 2, 0, 0, 1, 4'd1, 4'h9);
        // R10: every code against several flag states
        for (int st = 0; st < 16; st++) begin
            for (int cc = 0; cc < 16; cc++) begin
                apply("R7 preset", W'(st) << 28, 0, 0, 4, 0, 0, 0);
                apply("R10 code", 0, 0, 2, 1, 1, 4'(cc), 4'hF);
            end
        end
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            apply("mix", pick(), pick(), 2'($urandom), 3'($urandom),
                  1'($urandom), 4'($urandom), 4'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule